// File: doc/BRIEF.md
# Off-Delay Timer with Selectable Timebase

This block delays the release of an output after its enable input drops. While the enable is high, the output `q` is held high and the current count `cv` is held at zero. Once the enable goes low, `q` stays high and `cv` advances once per timebase tick. When `cv` reaches the preset, `q` goes low and counting stops. Raising the enable again at any time restarts the whole cycle.

Two timebases are available: hundredths of a second and tenths of a second. Both are derived from the system clock by an internal prescaler, which is sized by the `CLK_HZ` parameter. The preset comes from the `preset` port, which takes values from 0 to 32767. A value of all ones (-1) on that port selects an internally stored preset register instead. That register is written through a load port.

The timer state (`cv` and `q`) is retentive. The ordinary reset does not touch it. A separate synchronous clear input initialises it explicitly.

Top module: `offdelay_timer`

## Requirements
- R1: On every clock edge where `en` is 1 and `clr` is 0, `q` becomes 1 and `cv` becomes 0.
- R2: With `en` low, `q` high and no parameter error, `cv` increments by exactly 1 once per tick period. The first increment comes on the P-th clock edge with `en` low. P is `CLK_HZ/100` for `tb_sel` = 1 and `CLK_HZ/10` for `tb_sel` = 10.
- R3: `q` falls on the same edge on which `cv` becomes greater than or equal to the effective preset. After that, `cv` holds and `q` stays 0 until `en` or `clr` is asserted.
- R4: Raising `en` in the middle of a count returns `cv` to 0 with `q` = 1. The next low period of `en` times a full period again from its start.
- R5: A `tb_sel` value other than 1 or 10 sets `cfg_err` to 1. While this error is present, `cv` and `q` do not change with `en` low.
- R6: A `preset` value from 0 to 32767 is used directly as the preset. A preset of 0 makes `q` fall on the first edge with `en` low.
- R7: `preset` = 16'hFFFF selects the stored preset register. A one-cycle `pv_wr` pulse loads `pv_wr_data` into it when that value is non-negative; a negative value is ignored. `rst_n` low clears the register to 0.
- R8: A negative `preset` other than 16'hFFFF sets `cfg_err` to 1, and the timer freezes as in R5.
- R9: Holding `rst_n` low changes neither `cv` nor `q`. It restarts the prescaler.
- R10: `clr` high drives `cv` to 0 and `q` to 0 on the next edge, and it takes priority over `en`.
- R11: `cv` never exceeds 32767; its top bit is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset; clears the prescaler and the stored preset only |
| clr | input | 1 | Synchronous clear of the timer state (`cv` = 0, `q` = 0) |
| en | input | 1 | Enable; high holds the timer reset with `q` high |
| tb_sel | input | 8 | Timebase code: 1 = 0.01 s, 10 = 0.1 s |
| preset | input | 16 | Preset, 0..32767; 16'hFFFF selects the stored register |
| pv_wr | input | 1 | Load strobe for the stored preset register |
| pv_wr_data | input | 16 | Value loaded into the stored preset register |
| q | output | 1 | Timer output |
| cv | output | 16 | Current accumulated count |
| cfg_err | output | 1 | Invalid timebase code or invalid negative preset |

## Verification
Most internal faults in this block reach `cv` within one tick period.

- **Prescaler phase.** A wrong phase moves the first increment off the P-th edge after `en` falls. This is seen by sampling one edge before and one edge on that boundary.
- **Decade counter.** A wrong decade count in the coarse base makes the coarse period wrong on its first tick.
- **Done state.** A corrupted done state shows as `q` low while `cv` is still below the preset, or as `cv` moving after `q` has fallen.
- **Retention.** A reset wired into the retentive registers appears as soon as `rst_n` is pulsed while the timer is expired.

// File: rtl/odt_pkg.sv
// Shared constants and helpers for the off-delay timer.
// Assumes the timebase codes are unsigned and TB_W bits wide.
package odt_pkg;

    localparam int TB_W = 8;
    localparam logic [TB_W-1:0] TB_CODE_FINE   = TB_W'(1);
    localparam logic [TB_W-1:0] TB_CODE_COARSE = TB_W'(10);

    typedef enum logic [1:0] {
        BASE_FINE   = 2'd0,
        BASE_COARSE = 2'd1,
        BASE_NONE   = 2'd2
    } base_e;

    // Map a timebase code onto a timebase kind
    function automatic base_e decode_base(input logic [TB_W-1:0] code);
        if (code == TB_CODE_FINE)        return BASE_FINE;
        else if (code == TB_CODE_COARSE) return BASE_COARSE;
        else                             return BASE_NONE;
    endfunction

endpackage

// File: rtl/odt_prescaler.sv
// Tick generator for the off-delay timer.
// It emits one-cycle ticks every CLK_HZ/100 cycles (fine base) or every CLK_HZ/10
// cycles (coarse base, built as a decade count of fine periods).
// The phase is held at zero whenever run is low, so timing always starts cleanly.
// Assumes CLK_HZ is a multiple of 100.
module odt_prescaler #(
    parameter int CLK_HZ = 100_000_000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  odt_pkg::base_e base,
    output logic          tick
);
    import odt_pkg::*;

    localparam int FINE_DIV = CLK_HZ / 100;
    localparam int CW       = (FINE_DIV > 1) ? $clog2(FINE_DIV) : 1;
    localparam int DECADE   = 10;
    localparam int DW       = $clog2(DECADE);

    logic [CW-1:0] cyc_cnt;
    logic [DW-1:0] dec_cnt;
    logic          fine_wrap;
    logic          dec_last;

    assign fine_wrap = (cyc_cnt == CW'(FINE_DIV - 1));
    assign dec_last  = (dec_cnt == DW'(DECADE - 1));

    // Cycle and decade counters, cleared by reset or when not running
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cyc_cnt <= '0;
            dec_cnt <= '0;
        end else if (fine_wrap) begin
            cyc_cnt <= '0;
            dec_cnt <= dec_last ? '0 : dec_cnt + DW'(1);
        end else begin
            cyc_cnt <= cyc_cnt + CW'(1);
        end
    end

    // Select the tick for the chosen base
    always_comb begin
        unique case (base)
            BASE_FINE:   tick = run && fine_wrap;
            BASE_COARSE: tick = run && fine_wrap && dec_last;
            default:     tick = 1'b0;
        endcase
    end

endmodule

// File: rtl/odt_preset_sel.sv
// Preset selection for the off-delay timer.
// It holds the stored preset register (cleared by reset; negative loads are dropped).
// It picks the port preset or the stored one, and flags negative presets other than all ones.
module odt_preset_sel #(
    parameter int PV_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PV_W-1:0] preset,
    input  logic            pv_wr,
    input  logic [PV_W-1:0] pv_wr_data,
    output logic [PV_W-2:0] pv_eff,
    output logic            pv_bad
);
    localparam logic [PV_W-1:0] USE_STORED = '1;

    logic [PV_W-2:0] pv_store;
    logic            sel_stored;

    // Stored preset register; only non-negative values are accepted
    always_ff @(posedge clk) begin
        if (!rst_n)
            pv_store <= '0;
        else if (pv_wr && !pv_wr_data[PV_W-1])
            pv_store <= pv_wr_data[PV_W-2:0];
    end

    // Effective preset and validity
    always_comb begin
        sel_stored = (preset == USE_STORED);
        pv_bad     = preset[PV_W-1] && !sel_stored;
        pv_eff     = sel_stored ? pv_store : preset[PV_W-2:0];
    end

endmodule

// File: rtl/odt_core.sv
// Retentive count/output state of the off-delay timer.
// CV and Q carry no reset on purpose; only clr and en initialise them.
// Q falls on the edge where the next CV value meets the preset. CV saturates at its maximum.
module odt_core #(
    parameter int PV_W = 16
) (
    input  logic            clk,
    input  logic            clr,
    input  logic            en,
    input  logic            hold,
    input  logic            tick,
    input  logic [PV_W-2:0] pv_eff,
    output logic            q,
    output logic [PV_W-1:0] cv
);
    localparam logic [PV_W-1:0] CV_MAX = {1'b0, {(PV_W-1){1'b1}}};

    logic [PV_W-1:0] pv_ext;
    logic [PV_W-1:0] cv_nxt;

    assign pv_ext = {1'b0, pv_eff};

    // Candidate next count: advance on a tick while below the preset and the ceiling
    always_comb begin
        if (tick && (cv < pv_ext) && (cv != CV_MAX))
            cv_nxt = cv + PV_W'(1);
        else
            cv_nxt = cv;
    end

    // Timer state update; clear has priority, then enable, then timing
    always_ff @(posedge clk) begin
        if (clr) begin
            cv <= '0;
            q  <= 1'b0;
        end else if (en) begin
            cv <= '0;
            q  <= 1'b1;
        end else if (q && !hold) begin
            cv <= cv_nxt;
            q  <= !(cv_nxt >= pv_ext);
        end
    end

endmodule

// File: rtl/offdelay_timer.sv
// Off-delay timer top level.
// The enable high holds Q high and CV at zero. After the enable falls, CV counts
// timebase ticks and Q drops once CV reaches the preset. The state is retentive
// across rst_n; clr initialises it.
module offdelay_timer #(
    parameter int CLK_HZ = 100_000_000,
    parameter int PV_W   = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   clr,
    input  logic                   en,
    input  logic [odt_pkg::TB_W-1:0] tb_sel,
    input  logic [PV_W-1:0]        preset,
    input  logic                   pv_wr,
    input  logic [PV_W-1:0]        pv_wr_data,
    output logic                   q,
    output logic [PV_W-1:0]        cv,
    output logic                   cfg_err
);
    import odt_pkg::*;

    base_e           base;
    logic            pv_bad;
    logic [PV_W-2:0] pv_eff;
    logic            run;
    logic            tick;

    // Configuration checks
    always_comb begin
        base    = decode_base(tb_sel);
        cfg_err = (base == BASE_NONE) || pv_bad;
        run     = rst_n && !clr && !en && q && !cfg_err;
    end

    odt_preset_sel #(.PV_W(PV_W)) u_psel (
        .clk        (clk),
        .rst_n      (rst_n),
        .preset     (preset),
        .pv_wr      (pv_wr),
        .pv_wr_data (pv_wr_data),
        .pv_eff     (pv_eff),
        .pv_bad     (pv_bad)
    );

    odt_prescaler #(.CLK_HZ(CLK_HZ)) u_presc (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .base  (base),
        .tick  (tick)
    );

    odt_core #(.PV_W(PV_W)) u_core (
        .clk    (clk),
        .clr    (clr),
        .en     (en),
        .hold   (cfg_err),
        .tick   (tick),
        .pv_eff (pv_eff),
        .q      (q),
        .cv     (cv)
    );

endmodule

// File: rtl/odt_checker.sv
// Property checker for the off-delay timer, bound to the top.
// The state is retentive and undefined until its first clr or en. Properties on that
// state therefore wait for a seen-initialised flag.
module odt_checker #(
    parameter int PV_W = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic            clr,
    input logic            en,
    input logic            q,
    input logic [PV_W-1:0] cv,
    input logic            cfg_err,
    input logic [PV_W-2:0] pv_eff
);
    logic seen = 1'b0;

    // Record that the retentive state has been initialised
    always_ff @(posedge clk) begin
        if (clr || en) seen <= 1'b1;
    end

    AST_EN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !clr) |=> (q && cv == '0));  // R1

    AST_CV_STEP: assert property (@(posedge clk) disable iff (!rst_n || !seen)
        (!en && !clr) |=> (cv == $past(cv) || cv == $past(cv) + PV_W'(1)));  // R2

    AST_Q_FALL_AT_PV: assert property (@(posedge clk) disable iff (!rst_n || !seen)
        (q && !en && !clr) |=> (q || cv >= {1'b0, pv_eff}));  // R3

    AST_EXPIRED_STAYS: assert property (@(posedge clk) disable iff (!rst_n || !seen)
        (!q && !en && !clr) |=> (!q && $stable(cv)));  // R3

    AST_ERR_FREEZE: assert property (@(posedge clk) disable iff (!rst_n || !seen)
        (cfg_err && !en && !clr) |=> ($stable(cv) && $stable(q)));  // R5

    AST_CLR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (!q && cv == '0));  // R10

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n || !seen)
        !cv[PV_W-1]);  // R11

endmodule

bind offdelay_timer odt_checker #(.PV_W(PV_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (clr),
    .en      (en),
    .q       (q),
    .cv      (cv),
    .cfg_err (cfg_err),
    .pv_eff  (pv_eff)
);

// File: tb/offdelay_timer_tb.sv
// Directed bench for the off-delay timer; CLK_HZ=500 gives fine ticks every 5
// cycles and coarse ticks every 50 cycles.
module offdelay_timer_tb;

    localparam int CLK_HZ = 500;
    localparam int FINE   = CLK_HZ / 100;
    localparam int COARSE = CLK_HZ / 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        clr;
    logic        en;
    logic [7:0]  tb_sel;
    logic [15:0] preset;
    logic        pv_wr;
    logic [15:0] pv_wr_data;
    logic        q;
    logic [15:0] cv;
    logic        cfg_err;

    int n_chk  = 0;
    int n_bad  = 0;
    bit done   = 1'b0;
    bit armed  = 1'b0;
    bit top_hi = 1'b0;

    always #2 clk = ~clk;

    offdelay_timer #(.CLK_HZ(CLK_HZ)) u_dut (
        .clk(clk), .rst_n(rst_n), .clr(clr), .en(en), .tb_sel(tb_sel),
        .preset(preset), .pv_wr(pv_wr), .pv_wr_data(pv_wr_data),
        .q(q), .cv(cv), .cfg_err(cfg_err)
    );

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic chk_state(input string tag, input int exp_cv, input bit exp_q);
        chk(cv == 16'(exp_cv), {tag, " cv"}, int'(cv), exp_cv);
        chk(q == exp_q, {tag, " q"}, int'(q), int'(exp_q));
    endtask

    task automatic rearm();
        en = 1'b1;
        step(1);
    endtask

    // Watch the top bit of cv once the state is initialised (R11)
    always @(negedge clk) if (armed && cv[15]) top_hi = 1'b1;

    task automatic t_init();
        rst_n = 1'b0; clr = 1'b0; en = 1'b0; tb_sel = 8'd1;
        preset = 16'd3; pv_wr = 1'b0; pv_wr_data = '0;
        step(2);
        rst_n = 1'b1;
        clr = 1'b1;
        step(1);
        clr = 1'b0;
        armed = 1'b1;
        chk_state("R10 clear", 0, 1'b0);
        chk(cfg_err == 1'b0, "R5 no err", int'(cfg_err), 0);
    endtask

    task automatic t_enable();
        en = 1'b1;
        step(1);
        chk_state("R1 enable", 0, 1'b1);
        step(3);
        chk_state("R1 enable held", 0, 1'b1);
    endtask

    task automatic t_fine();
        preset = 16'd3; tb_sel = 8'd1;
        en = 1'b0;
        step(FINE - 1);
        chk_state("R2 fine before tick", 0, 1'b1);
        step(1);
        chk_state("R2 fine first tick", 1, 1'b1);
        step(2 * FINE - 1);
        chk_state("R3 before preset", 2, 1'b1);
        step(1);
        chk_state("R3 at preset", 3, 1'b0);
        step(20);
        chk_state("R3 stays expired", 3, 1'b0);
    endtask

    task automatic t_retain();
        rst_n = 1'b0;
        step(3);
        chk_state("R9 in reset", 3, 1'b0);
        rst_n = 1'b1;
        step(1);
        chk_state("R9 after reset", 3, 1'b0);
    endtask

    task automatic t_stored_cleared();
        rearm();
        preset = 16'hFFFF;
        en = 1'b0;
        step(1);
        chk_state("R7 stored cleared by reset", 0, 1'b0);
    endtask

    task automatic t_coarse();
        rearm();
        preset = 16'd2; tb_sel = 8'd10;
        en = 1'b0;
        step(COARSE - 1);
        chk_state("R2 coarse before tick", 0, 1'b1);
        step(1);
        chk_state("R2 coarse first tick", 1, 1'b1);
        step(COARSE);
        chk_state("R3 coarse expiry", 2, 1'b0);
    endtask

    task automatic t_restart();
        rearm();
        tb_sel = 8'd1; preset = 16'd10;
        en = 1'b0;
        step(3 * FINE);
        chk_state("R4 mid count", 3, 1'b1);
        en = 1'b1;
        step(1);
        chk_state("R4 restart", 0, 1'b1);
        en = 1'b0;
        step(FINE - 1);
        chk_state("R4 phase fresh", 0, 1'b1);
        step(1);
        chk_state("R4 first tick again", 1, 1'b1);
    endtask

    task automatic t_bad_code();
        rearm();
        preset = 16'd2; tb_sel = 8'd7;
        step(1);
        chk(cfg_err == 1'b1, "R5 err flagged", int'(cfg_err), 1);
        en = 1'b0;
        step(30);
        chk_state("R5 frozen", 0, 1'b1);
        tb_sel = 8'd1;
        step(1);
        chk(cfg_err == 1'b0, "R5 err clears", int'(cfg_err), 0);
    endtask

    task automatic t_pv_zero();
        rearm();
        preset = 16'd0;
        en = 1'b0;
        step(1);
        chk_state("R6 zero preset", 0, 1'b0);
    endtask

    task automatic t_stored();
        rearm();
        pv_wr = 1'b1; pv_wr_data = 16'd4;
        step(1);
        pv_wr_data = 16'hFFFB;
        step(1);
        pv_wr = 1'b0;
        preset = 16'hFFFF;
        en = 1'b0;
        step(4 * FINE - 1);
        chk_state("R7 stored before", 3, 1'b1);
        step(1);
        chk_state("R7 stored expiry", 4, 1'b0);
    endtask

    task automatic t_bad_preset();
        rearm();
        preset = 16'hFFFD;
        step(1);
        chk(cfg_err == 1'b1, "R8 err flagged", int'(cfg_err), 1);
        en = 1'b0;
        step(20);
        chk_state("R8 frozen", 0, 1'b1);
    endtask

    task automatic t_clr_priority();
        preset = 16'd5;
        en = 1'b1; clr = 1'b1;
        step(1);
        chk_state("R10 clr over en", 0, 1'b0);
        clr = 1'b0;
        step(1);
        chk_state("R1 after clr", 0, 1'b1);
        chk(top_hi == 1'b0, "R11 cv ceiling", int'(top_hi), 0);
    endtask

    initial begin
        t_init();
        t_enable();
        t_fine();
        t_retain();
        t_stored_cleared();
        t_coarse();
        t_restart();
        t_bad_code();
        t_pv_zero();
        t_stored();
        t_bad_preset();
        t_clr_priority();
        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

endmodule